// File: doc/BRIEF.md
# Link Primitive Sequence Controller

This block is the link-level state machine of a serial fabric port. After power-on it transmits the offline sequence and waits for its peer. It then runs a two-step handshake to bring the link up, and afterwards it watches for conditions that break the link. It receives one decoded word code per clock. Its outputs are the code of the primitive sequence that the transmitter must repeat, a link-up flag, a login flag, and a transmit enable that opens the data path only while the link is up and a login is held.

There are two recovery paths, and each has its own trigger causes. A failure is caused by loss of synchronization, loss of signal, or a stalled handshake. It sends the not-operational sequence and waits until the peer is offline and the line is clean. A reset is caused by a link timeout or a buffer-to-buffer overflow. It goes straight back into the handshake. Both paths come back through initialization, so a fresh login is needed before data may flow again. A logout removes the login without taking the link down.

Sequence codes are 3 bits: OFFLINE=0, NOS=1, LR=2, LRR=3, IDLE=4. The values 5 to 7 mean a word that is not a primitive sequence.

Top module: `link_seq_ctrl`

## Requirements
- R1: A synchronous active-high reset gives tx_seq=0 (OFFLINE), link_up=0, logged_in=0 and tx_enable=0 one cycle later.
- R2: A received code counts as recognized only after the same code (0..4) has arrived on RUN_LEN consecutive cycles. Codes 5..7 are never recognized, and shorter runs have no effect.
- R3: The initialization order is fixed. In OFFLINE, a recognized OFFLINE moves to transmit LR (2). In LR, a recognized LR or LRR moves to transmit LRR (3). In LRR, a recognized IDLE or LRR moves to the active state, which transmits IDLE (4).
- R4: link_up is 1 only in the active state. tx_enable equals link_up AND logged_in.
- R5: login_req sets logged_in only while the link is already active. In any other state it is ignored.
- R6: logout_req clears logged_in and keeps the link up. When login_req and logout_req arrive together, logout wins.
- R7: In the active state or in initialization, loss_sync or loss_sig moves to the failure state. This state transmits NOS (1) and drops link_up and logged_in. Failure takes priority over reset.
- R8: In the active state, link_tmo or bb_ovf (with no loss indication) moves back to transmit LR and drops link_up and logged_in.
- R9: The failure state is left only when both loss inputs are low and OFFLINE is recognized. The next state transmits LR.
- R10: Any non-active state held for TMO_CYCLES cycles moves to the failure state (NOS). No timeout applies in the active state.
- R11: tx_seq stays steady while the state stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_seq | input | 3 | Decoded received word code (0..4 sequences, 5..7 other) |
| loss_sync | input | 1 | Receiver lost word synchronization |
| loss_sig | input | 1 | Receiver lost signal |
| link_tmo | input | 1 | Link timeout flag from upper logic |
| bb_ovf | input | 1 | Buffer-to-buffer credit overflow flag |
| login_req | input | 1 | Request to establish a login |
| logout_req | input | 1 | Request to end the login |
| tx_seq | output | 3 | Primitive sequence code to transmit continuously |
| link_up | output | 1 | Link is in the active state |
| logged_in | output | 1 | A login is held |
| tx_enable | output | 1 | Data frames may be sent |

## Verification
The bench builds the block with RUN_LEN=3 and TMO_CYCLES=40. The short timeout makes the timeout path testable in a short run: the bench holds an initialization state just under the limit, then just over it, and also checks that the active state outlasts the limit. RUN_LEN=3 keeps recognition exact. The bench feeds broken runs of two words and alternating codes, which must not advance the state, and a clean run of three words, which must.

// File: rtl/lpsc_pkg.sv
package lpsc_pkg;
  localparam int PS_W = 3;

  typedef enum logic [PS_W-1:0] {
    PS_OFFLINE = 3'd0,
    PS_NOS     = 3'd1,
    PS_LR      = 3'd2,
    PS_LRR     = 3'd3,
    PS_IDLE    = 3'd4
  } ps_code_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_INIT_LR,
    ST_INIT_LRR,
    ST_ACTIVE,
    ST_FAIL
  } link_st_e;

  function automatic logic [PS_W-1:0] st_to_code(link_st_e s);
    case (s)
      ST_INIT_LR:  return PS_LR;
      ST_INIT_LRR: return PS_LRR;
      ST_ACTIVE:   return PS_IDLE;
      ST_FAIL:     return PS_NOS;
      default:     return PS_OFFLINE;
    endcase
  endfunction
endpackage

// File: rtl/lpsc_recog.sv
module lpsc_recog #(
  parameter int RUN_LEN = 3,
  parameter int CODE_W  = 3,
  parameter int MAX_SEQ = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] rx_code,
  output logic              hit,
  output logic [CODE_W-1:0] hit_code
);
  localparam int RW = $clog2(RUN_LEN + 1);

  logic [CODE_W-1:0] last_q;
  logic [RW-1:0]     run_q;
  logic [RW-1:0]     run_n;

  always_comb begin
    if (rx_code != last_q)           run_n = RW'(1);
    else if (run_q == RW'(RUN_LEN))  run_n = run_q;
    else                             run_n = run_q + RW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q   <= '1;
      run_q    <= '0;
      hit      <= 1'b0;
      hit_code <= '0;
    end else begin
      last_q   <= rx_code;
      run_q    <= run_n;
      hit      <= (run_n == RW'(RUN_LEN)) && (rx_code <= CODE_W'(MAX_SEQ));
      hit_code <= rx_code;
    end
  end
endmodule

// File: rtl/lpsc_timer.sv
module lpsc_timer #(
  parameter int TMO_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic enable,
  output logic expire
);
  localparam int TW = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;

  logic [TW-1:0] cnt_q;

  assign expire = enable && (cnt_q == TW'(TMO_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst || restart || !enable) cnt_q <= '0;
    else                           cnt_q <= cnt_q + TW'(1);
  end
endmodule

// File: rtl/lpsc_fsm.sv
module lpsc_fsm
  import lpsc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            hit,
  input  logic [PS_W-1:0] hit_code,
  input  logic            expire,
  input  logic            loss_sync,
  input  logic            loss_sig,
  input  logic            link_tmo,
  input  logic            bb_ovf,
  input  logic            login_req,
  input  logic            logout_req,
  output logic            tmr_restart,
  output logic            tmr_enable,
  output logic [PS_W-1:0] tx_seq,
  output logic            link_up,
  output logic            logged_in,
  output logic            tx_enable
);
  link_st_e st_q, st_n;
  logic     loss, li_n;

  assign loss = loss_sync || loss_sig;

  always_comb begin
    st_n = st_q;
    case (st_q)
      ST_OFF: begin
        if (expire)                                   st_n = ST_FAIL;
        else if (hit && hit_code == PS_OFFLINE)       st_n = ST_INIT_LR;
      end
      ST_INIT_LR: begin
        if (loss || expire)                           st_n = ST_FAIL;
        else if (hit && (hit_code == PS_LR || hit_code == PS_LRR))
                                                      st_n = ST_INIT_LRR;
      end
      ST_INIT_LRR: begin
        if (loss || expire)                           st_n = ST_FAIL;
        else if (hit && (hit_code == PS_IDLE || hit_code == PS_LRR))
                                                      st_n = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (loss)                                     st_n = ST_FAIL;
        else if (link_tmo || bb_ovf)                  st_n = ST_INIT_LR;
      end
      ST_FAIL: begin
        if (!loss && hit && hit_code == PS_OFFLINE)   st_n = ST_INIT_LR;
      end
      default:                                        st_n = ST_OFF;
    endcase
  end

  assign li_n = (st_q == ST_ACTIVE) && (st_n == ST_ACTIVE) &&
                !logout_req && (logged_in || login_req);

  assign tmr_enable  = (st_q != ST_ACTIVE);
  assign tmr_restart = (st_n != st_q) || expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_OFF;
      tx_seq    <= PS_OFFLINE;
      link_up   <= 1'b0;
      logged_in <= 1'b0;
      tx_enable <= 1'b0;
    end else begin
      st_q      <= st_n;
      tx_seq    <= st_to_code(st_n);
      link_up   <= (st_n == ST_ACTIVE);
      logged_in <= li_n;
      tx_enable <= (st_n == ST_ACTIVE) && li_n;
    end
  end
endmodule

// File: rtl/link_seq_ctrl.sv
module link_seq_ctrl
  import lpsc_pkg::*;
#(
  parameter int RUN_LEN    = 3,
  parameter int TMO_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] rx_seq,
  input  logic       loss_sync,
  input  logic       loss_sig,
  input  logic       link_tmo,
  input  logic       bb_ovf,
  input  logic       login_req,
  input  logic       logout_req,
  output logic [2:0] tx_seq,
  output logic       link_up,
  output logic       logged_in,
  output logic       tx_enable
);
  logic            hit, expire, tmr_restart, tmr_enable;
  logic [PS_W-1:0] hit_code;

  lpsc_recog #(.RUN_LEN(RUN_LEN), .CODE_W(PS_W), .MAX_SEQ(int'(PS_IDLE))) u_recog (
    .clk(clk), .rst(rst), .rx_code(rx_seq), .hit(hit), .hit_code(hit_code)
  );

  lpsc_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .restart(tmr_restart), .enable(tmr_enable), .expire(expire)
  );

  lpsc_fsm u_fsm (
    .clk(clk), .rst(rst), .hit(hit), .hit_code(hit_code), .expire(expire),
    .loss_sync(loss_sync), .loss_sig(loss_sig), .link_tmo(link_tmo), .bb_ovf(bb_ovf),
    .login_req(login_req), .logout_req(logout_req),
    .tmr_restart(tmr_restart), .tmr_enable(tmr_enable),
    .tx_seq(tx_seq), .link_up(link_up), .logged_in(logged_in), .tx_enable(tx_enable)
  );
endmodule

// File: rtl/link_seq_ctrl_chk.sv
module link_seq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       loss_sync,
  input logic       loss_sig,
  input logic       link_tmo,
  input logic       bb_ovf,
  input logic       login_req,
  input logic       logout_req,
  input logic [2:0] tx_seq,
  input logic       link_up,
  input logic       logged_in,
  input logic       tx_enable
);
  p_rst_state_r1: assert property (@(posedge clk)
    rst |=> (tx_seq == 3'd0 && !link_up && !logged_in && !tx_enable));

  p_entry_order_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(link_up) |-> $past(tx_seq) == 3'd3);

  p_up_idle_r4: assert property (@(posedge clk) disable iff (rst)
    link_up |-> tx_seq == 3'd4);

  p_txen_r4: assert property (@(posedge clk) disable iff (rst)
    tx_enable == (link_up && logged_in));

  p_login_gate_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(logged_in) |-> ($past(link_up) && $past(login_req)));

  p_logout_r6: assert property (@(posedge clk) disable iff (rst)
    (link_up && logout_req && !loss_sync && !loss_sig && !link_tmo && !bb_ovf)
      |=> (!logged_in && link_up));

  p_fail_r7: assert property (@(posedge clk) disable iff (rst)
    (link_up && (loss_sync || loss_sig)) |=> (tx_seq == 3'd1 && !link_up && !logged_in));

  p_reset_r8: assert property (@(posedge clk) disable iff (rst)
    (link_up && !loss_sync && !loss_sig && (link_tmo || bb_ovf))
      |=> (tx_seq == 3'd2 && !link_up));

  p_fail_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_seq == 3'd1 && (loss_sync || loss_sig)) |=> tx_seq == 3'd1);
endmodule

bind link_seq_ctrl link_seq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .loss_sync(loss_sync), .loss_sig(loss_sig),
  .link_tmo(link_tmo), .bb_ovf(bb_ovf), .login_req(login_req),
  .logout_req(logout_req), .tx_seq(tx_seq), .link_up(link_up),
  .logged_in(logged_in), .tx_enable(tx_enable)
);

// File: tb/test_link_seq_ctrl.sv
module test_link_seq_ctrl;
  typedef struct packed {
    logic       ls, lg, tmo, ovf, li, lo;
    logic [2:0] rx;
    logic [7:0] hold;
    logic [2:0] e_tx;
    logic       e_up, e_li;
    logic [3:0] req;
  } vec_t;

  function automatic vec_t mk(logic ls, logic lg, logic tmo, logic ovf, logic li, logic lo,
                              logic [2:0] rx, logic [7:0] hold, logic [2:0] e_tx,
                              logic e_up, logic e_li, logic [3:0] req);
    return '{ls:ls, lg:lg, tmo:tmo, ovf:ovf, li:li, lo:lo, rx:rx, hold:hold,
             e_tx:e_tx, e_up:e_up, e_li:e_li, req:req};
  endfunction

  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    mk(0,0,0,0,1,0, 7,  5, 0,0,0, 5),  // R5 login before link is up ignored
    mk(0,0,0,0,0,0, 0,  6, 2,0,0, 3),  // R3 offline seen -> LR
    mk(0,0,0,0,0,0, 2,  6, 3,0,0, 3),  // R3 LR seen -> LRR
    mk(0,0,0,0,0,0, 4,  6, 4,1,0, 3),  // R3 idle seen -> active
    mk(0,0,0,0,1,0, 4,  3, 4,1,1, 5),  // R5 login accepted
    mk(0,0,0,0,0,0, 4,  3, 4,1,1, 4),  // R4 login held
    mk(0,0,0,0,0,1, 4,  3, 4,1,0, 6),  // R6 logout, link stays
    mk(0,0,0,0,1,0, 4,  3, 4,1,1, 5),
    mk(0,0,1,0,0,0, 4,  2, 2,0,0, 8),  // R8 timeout flag -> LR
    mk(0,0,0,0,0,0, 2,  6, 3,0,0, 3),
    mk(0,0,0,0,0,0, 4,  6, 4,1,0, 8),  // R8 login not kept across reset
    mk(0,0,0,0,1,0, 4,  2, 4,1,1, 5),
    mk(0,0,0,1,0,0, 4,  2, 2,0,0, 8),  // R8 overflow -> LR
    mk(0,0,0,0,0,0, 2,  6, 3,0,0, 3),
    mk(0,0,0,0,0,0, 4,  6, 4,1,0, 3),
    mk(0,0,0,0,1,0, 4,  2, 4,1,1, 5),
    mk(1,0,0,0,0,0, 4,  2, 1,0,0, 7),  // R7 loss of sync -> NOS
    mk(1,0,0,0,0,0, 0,  6, 1,0,0, 9),  // R9 offline seen but sync still lost
    mk(0,0,0,0,0,0, 0,  6, 2,0,0, 9),  // R9 clean + offline -> LR
    mk(0,0,0,0,0,0, 2,  6, 3,0,0, 3),
    mk(0,0,0,0,0,0, 4,  6, 4,1,0, 3),
    mk(0,1,1,0,0,0, 4,  2, 1,0,0, 7),  // R7 loss of signal beats timeout flag
    mk(0,0,0,0,0,0, 7, 45, 1,0,0, 10), // R10 expiry in failure keeps NOS
    mk(0,0,0,0,0,0, 0,  5, 2,0,0, 9),
    mk(0,0,0,0,0,0, 7, 36, 2,0,0, 10), // R10 just under limit
    mk(0,0,0,0,0,0, 7,  8, 1,0,0, 10), // R10 over limit -> NOS
    mk(0,0,0,0,0,0, 0,  6, 2,0,0, 9),
    mk(0,0,0,0,0,0, 2,  6, 3,0,0, 3),
    mk(0,0,0,0,0,0, 4, 60, 4,1,0, 10), // R10 no timeout while active
    mk(0,0,0,0,1,1, 4,  2, 4,1,0, 6),  // R6 logout wins over login
    mk(0,0,0,0,1,0, 4,  2, 4,1,1, 5),
    mk(0,0,0,0,0,1, 4,  2, 4,1,0, 6)
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] rx_seq = 3'd7;
  logic       loss_sync = 0, loss_sig = 0, link_tmo = 0, bb_ovf = 0;
  logic       login_req = 0, logout_req = 0;
  logic [2:0] tx_seq;
  logic       link_up, logged_in, tx_enable;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  link_seq_ctrl #(.RUN_LEN(3), .TMO_CYCLES(40)) i_link_seq_ctrl (
    .clk(clk), .rst(rst), .rx_seq(rx_seq), .loss_sync(loss_sync), .loss_sig(loss_sig),
    .link_tmo(link_tmo), .bb_ovf(bb_ovf), .login_req(login_req), .logout_req(logout_req),
    .tx_seq(tx_seq), .link_up(link_up), .logged_in(logged_in), .tx_enable(tx_enable)
  );

  task automatic check(string req, logic [2:0] e_tx, logic e_up, logic e_li);
    logic [5:0] act, exp;
    act = {tx_seq, link_up, logged_in, tx_enable};
    exp = {e_tx, e_up, e_li, e_up & e_li};
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: tx/up/li/en actual=%0d/%0b/%0b/%0b expected=%0d/%0b/%0b/%0b",
               req, tx_seq, link_up, logged_in, tx_enable, e_tx, e_up, e_li, e_up & e_li);
    end
  endtask

  task automatic drive(logic [2:0] rx, int cyc);
    rx_seq = rx;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 3'd0, 0, 0);            // R1 reset state
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      loss_sync  = VEC[i].ls;
      loss_sig   = VEC[i].lg;
      link_tmo   = VEC[i].tmo;
      bb_ovf     = VEC[i].ovf;
      login_req  = VEC[i].li;
      logout_req = VEC[i].lo;
      rx_seq     = VEC[i].rx;
      repeat (int'(VEC[i].hold)) @(negedge clk);
      check($sformatf("R%0d step %0d", VEC[i].req, i), VEC[i].e_tx, VEC[i].e_up, VEC[i].e_li);
    end
    loss_sync = 0; loss_sig = 0; link_tmo = 0; bb_ovf = 0; login_req = 0; logout_req = 0;

    // R2: broken runs of two never recognized
    link_tmo = 1;
    drive(3'd4, 2);
    link_tmo = 0;
    check("R8 re-enter LR", 3'd2, 0, 0);
    for (int k = 0; k < 8; k++) begin
      drive(3'd2, 2);
      drive(3'd7, 1);
    end
    check("R2 runs of two ignored", 3'd2, 0, 0);
    for (int k = 0; k < 4; k++) begin
      drive(3'd2, 1);
      drive(3'd3, 1);
    end
    check("R2 alternating codes ignored", 3'd2, 0, 0);
    drive(3'd2, 3);
    drive(3'd7, 3);
    check("R2 run of three recognized", 3'd3, 0, 0);
    drive(3'd5, 6);
    check("R2 non-sequence code ignored", 3'd3, 0, 0);

    // R1: reset in the middle of operation
    drive(3'd4, 6);
    login_req = 1;
    drive(3'd4, 2);
    login_req = 0;
    check("R5 login", 3'd4, 1, 1);
    rst = 1;
    drive(3'd4, 2);
    check("R1 reset mid-operation", 3'd0, 0, 0);
    rst = 0;
    drive(3'd7, 4);
    check("R11 offline held", 3'd0, 0, 0);

    finish_up();
  end
endmodule